// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one 32-bit integer by another with the restoring long-division method and produces one quotient bit per clock. A single-cycle start pulse captures the dividend, the divisor and a mode select that chooses between unsigned and two's-complement operands. The iterations then run without further input. When they finish, the quotient is placed in the LO result register and the remainder in the HI result register, and a one-cycle done pulse is raised.

In each iteration the partial remainder is shifted left and the next dividend bit is brought in. The divisor magnitude is then subtracted from it. A non-negative result is kept and gives a quotient bit of 1. A negative result has the divisor added back and gives a quotient bit of 0.

Signed operation works on magnitudes. The signs of the quotient and remainder are set in a final fix-up cycle. Overflow and a zero divisor never stop the block. A zero divisor is reported on a status flag that stays valid alongside HI and LO.

Top module: `div_restoring`

## Requirements
- R1: After reset, done, divZero, hi and lo are all 0.
- R2: With isSigned=0 and a non-zero divisor, lo equals the unsigned quotient floor(dividend/divisor) and hi equals the unsigned remainder. Bit patterns such as 0xFFFFFFFF are treated as large positive values.
- R3: With isSigned=1 and a non-zero divisor, the quotient is rounded toward zero and is negative when exactly one operand is negative. The remainder carries the sign of the dividend, its magnitude is below the divisor magnitude, and lo*divisor+hi equals the dividend modulo 2^32.
- R4: done rises at the 33rd rising clock edge after the edge that samples start, and it stays high for exactly one cycle. hi, lo and divZero change only at that edge and hold their values afterwards.
- R5: With a zero divisor, in either mode, the operation takes the same time as any other. It returns lo=0xFFFFFFFF and hi equal to the dividend, with divZero=1. Any non-zero divisor gives divZero=0.
- R6: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns lo=0x80000000, hi=0 and divZero=0, with no other indication.
- R7: Once an operation is running, start pulses and changes to dividend, divisor or isSigned have no effect on its result or on its completion time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only when the block is idle |
| isSigned | input | 1 | 1 selects two's-complement operands, 0 unsigned |
| dividend | input | 32 | Dividend, captured with start |
| divisor | input | 32 | Divisor, captured with start |
| done | output | 1 | One-cycle pulse when hi/lo/divZero are updated |
| divZero | output | 1 | Last completed division had a zero divisor |
| hi | output | 32 | Remainder of the last completed division |
| lo | output | 32 | Quotient of the last completed division |

## Verification
The bench targets sign fix-up cases where a design could negate the wrong result: a negative dividend with a positive divisor, and the reverse. A design that follows the divisor's sign for the remainder, or that rounds toward minus infinity, returns a remainder with the wrong sign or a quotient that is off by one. The bench also covers the most negative dividend divided by minus one and divided by one, where a faulty magnitude path wraps or flags an error. Zero-divisor cases in both modes are included, where a design that applies the sign fix-up to the all-ones quotient returns 1 instead. A start pulse and operand changes in the middle of an operation catch a design that restarts or re-samples its inputs. This phase is mixed with a long run of seeded random operands, with small divisors weighted in so that large quotients appear.

// File: rtl/div_pkg.sv
package div_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands and form magnitudes
    logic step;    // one restoring iteration
    logic finish;  // sign fix-up and result write
  } divCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } divState_e;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output divCtl_t ctl
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_e      state;
  logic [CW-1:0]  stepCount;
  logic           lastStep;

  assign lastStep = (stepCount == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCount <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            stepCount <= '0;
          end
        end
        ST_RUN: begin
          stepCount <= stepCount + 1'b1;
          if (lastStep) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_FINISH);
  end

  // R4: the run phase is not cut short before the last iteration
  p_run_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastStep) |=> (state == ST_RUN));

  // R4: the last iteration is followed by exactly one fix-up cycle
  p_finish_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && lastStep) |=> (state == ST_FINISH));

  // R7: a start pulse during a run neither restarts nor stalls the count
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && !lastStep) |=>
      (state == ST_RUN && stepCount == $past(stepCount) + 1'b1));

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] remIn,
  input  logic             nextBit,
  input  logic [WIDTH-1:0] dvsMag,
  output logic [WIDTH-1:0] remOut,
  output logic             quotBit
);

  localparam int SW = WIDTH + 2;

  logic [SW-1:0] shifted;
  logic [SW-1:0] trial;
  logic [SW-1:0] restored;
  logic          wentNeg;

  always_comb begin
    shifted  = {1'b0, remIn, nextBit};
    trial    = shifted - {2'b00, dvsMag};
    wentNeg  = trial[SW-1];
    // Negative trial: the divisor is added back to recover the old value
    restored = trial + {2'b00, dvsMag};
    remOut   = wentNeg ? restored[WIDTH-1:0] : trial[WIDTH-1:0];
    quotBit  = ~wentNeg;
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtl_t          ctl,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic             divZero,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  logic [WIDTH-1:0] dvsMag;
  logic [WIDTH-1:0] quotReg;
  logic [WIDTH-1:0] remReg;
  logic             negQuot;
  logic             negRem;
  logic             zeroDvs;

  logic             dvdNeg;
  logic             dvsNeg;
  logic [WIDTH-1:0] remNext;
  logic             quotBit;

  assign dvdNeg = isSigned & dividend[WIDTH-1];
  assign dvsNeg = isSigned & divisor[WIDTH-1];

  div_step #(.WIDTH(WIDTH)) u_step (
    .remIn   (remReg),
    .nextBit (quotReg[WIDTH-1]),
    .dvsMag  (dvsMag),
    .remOut  (remNext),
    .quotBit (quotBit)
  );

  // Iteration registers: the quotient register starts as the dividend
  // magnitude and shifts quotient bits in as dividend bits shift out.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvsMag  <= '0;
      quotReg <= '0;
      remReg  <= '0;
      negQuot <= 1'b0;
      negRem  <= 1'b0;
      zeroDvs <= 1'b0;
    end else if (ctl.load) begin
      dvsMag  <= dvsNeg ? (~divisor + 1'b1) : divisor;
      quotReg <= dvdNeg ? (~dividend + 1'b1) : dividend;
      remReg  <= '0;
      negQuot <= dvdNeg ^ dvsNeg;
      negRem  <= dvdNeg;
      zeroDvs <= (divisor == '0);
    end else if (ctl.step) begin
      remReg  <= remNext;
      quotReg <= {quotReg[WIDTH-2:0], quotBit};
    end
  end

  // Result registers with sign fix-up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hi      <= '0;
      lo      <= '0;
      divZero <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        lo      <= zeroDvs ? '1 : (negQuot ? (~quotReg + 1'b1) : quotReg);
        hi      <= negRem ? (~remReg + 1'b1) : remReg;
        divZero <= zeroDvs;
      end
    end
  end

  // R3: the partial remainder stays below the divisor magnitude
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && dvsMag != '0) |=> (remReg < dvsMag));

  // R3: a non-zero remainder carries the dividend's sign
  p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && negRem && hi != '0) |-> hi[WIDTH-1]);

  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: results hold between completions
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finish |=> ($stable(hi) && $stable(lo) && $stable(divZero)));

  // R5: a zero divisor yields an all-ones quotient
  p_dz_quot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZero) |-> (lo == '1));

endmodule

// File: rtl/div_restoring.sv
module div_restoring
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic             divZero,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  divCtl_t ctl;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .isSigned (isSigned),
    .dividend (dividend),
    .divisor  (divisor),
    .done     (done),
    .divZero  (divZero),
    .hi       (hi),
    .lo       (lo)
  );

endmodule

// File: tb/div_restoring_tb.sv
`timescale 1ns/1ps
module div_restoring_tb;

  localparam int LATENCY = 33;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isSigned = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        done;
  logic        divZero;
  logic [31:0] hi;
  logic [31:0] lo;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  div_restoring u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor),
    .done(done), .divZero(divZero), .hi(hi), .lo(lo)
  );

  function automatic logic [31:0] expQ(logic [31:0] a, logic [31:0] b, bit s);
    longint sa, sb;
    if (b == 0) return 32'hFFFF_FFFF;
    if (!s) return a / b;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 32'(sa / sb);
  endfunction

  function automatic logic [31:0] expR(logic [31:0] a, logic [31:0] b, bit s);
    longint sa, sb;
    if (b == 0) return a;
    if (!s) return a % b;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 32'(sa % sb);
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one division; optionally disturb the inputs mid-run (R7)
  task automatic runOp(logic [31:0] a, logic [31:0] b, bit s, bit disturb,
                       string req);
    int lat;
    logic [31:0] q, r, eq, er;
    longint lq, lr, lb, la, chk;
    @(negedge clk);
    dividend = a; divisor = b; isSigned = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (disturb && lat == 10) begin
        start = 1'b1; dividend = ~a; divisor = b + 32'd3; isSigned = ~s;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(lat == LATENCY, "R4", "latency", 32'(lat), 32'(LATENCY));
    q = lo; r = hi;
    eq = expQ(a, b, s); er = expR(a, b, s);
    check(q == eq, req, "quotient", q, eq);
    check(r == er, req, "remainder", r, er);
    check(divZero == (b == 0), "R5", "divZero", 32'(divZero), 32'(b == 0));
    if (b != 0) begin
      if (s) begin
        lq = longint'($signed(q)); lr = longint'($signed(r));
        lb = longint'($signed(b)); la = longint'($signed(a));
      end else begin
        lq = longint'({32'd0, q}); lr = longint'({32'd0, r});
        lb = longint'({32'd0, b}); la = longint'({32'd0, a});
      end
      chk = lq * lb + lr;
      check(32'(chk) == a, s ? "R3" : "R2", "q*d+r", 32'(chk), a);
      if (lr < 0) lr = -lr;
      if (lb < 0) lb = -lb;
      check(lr < lb, s ? "R3" : "R2", "|r|<|d|", 32'(lr), 32'(lb));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] holdHi, holdLo;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", 32'(done), 32'd0);
    check(divZero == 1'b0, "R1", "divZero", 32'(divZero), 32'd0);
    check(hi == 32'd0, "R1", "hi", hi, 32'd0);
    check(lo == 32'd0, "R1", "lo", lo, 32'd0);

    // R2 unsigned directed
    runOp(32'd100, 32'd7, 1'b0, 1'b0, "R2");
    runOp(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R2");
    runOp(32'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");
    runOp(32'd0, 32'd5, 1'b0, 1'b0, "R2");
    runOp(32'd7, 32'd7, 1'b0, 1'b0, "R2");
    runOp(32'h8000_0000, 32'd2, 1'b0, 1'b0, "R2");
    runOp(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");

    // R4 hold after completion
    holdHi = hi; holdLo = lo;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R4", "done after pulse", 32'(done), 32'd0);
    check(hi == holdHi, "R4", "hi hold", hi, holdHi);
    check(lo == holdLo, "R4", "lo hold", lo, holdLo);

    // R3 signed directed
    runOp(-32'sd7, 32'd2, 1'b1, 1'b0, "R3");
    runOp(32'd7, -32'sd2, 1'b1, 1'b0, "R3");
    runOp(-32'sd7, -32'sd2, 1'b1, 1'b0, "R3");
    runOp(32'h8000_0000, 32'd1, 1'b1, 1'b0, "R3");
    runOp(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, "R3");

    // R6 most negative by minus one
    runOp(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6");
    check(lo == 32'h8000_0000, "R6", "lo", lo, 32'h8000_0000);
    check(hi == 32'd0, "R6", "hi", hi, 32'd0);

    // R5 zero divisor, both modes
    runOp(32'd123, 32'd0, 1'b0, 1'b0, "R5");
    runOp(32'd5, 32'd0, 1'b1, 1'b0, "R5");
    runOp(-32'sd5, 32'd0, 1'b1, 1'b0, "R5");
    runOp(32'h8000_0000, 32'd0, 1'b1, 1'b0, "R5");
    check(lo == 32'hFFFF_FFFF, "R5", "lo all ones", lo, 32'hFFFF_FFFF);

    // R7 disturbance during a run
    runOp(32'd1000, 32'd33, 1'b0, 1'b1, "R7");
    runOp(-32'sd1000, 32'd33, 1'b1, 1'b1, "R7");

    // Random, both modes
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      bit s;
      a = $urandom;
      if (($urandom % 4) == 0) b = $urandom % 16;
      else if (($urandom % 3) == 0) b = $urandom % 65536;
      else b = $urandom;
      s = bit'(i % 2);
      runOp(a, b, s, 1'b0, s ? "R3" : "R2");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule